// File: doc/BRIEF.md
# Port Device Power State Controller

This block follows the device power state of a single switch port. It watches configuration writes to the Command register and to the power-state field of the power management control/status register. It also watches a memory-access-enable event, the serial EEPROM load-done flag, the L0s status of the upstream and downstream links, hot-plug events and the main power rail. Every change happens on a clock edge. The block presents the current state, the readback value of the power-state field, a one-cycle PME request and an enable that says whether configuration requests may still be answered.

Four states exist: D0 uninitialized, D0 active, D3hot and D3cold. The intermediate low-power states are not provided. Leaving D3hot needs a software write of D0 while both links sit in L0s. Losing main power always ends in D3cold, and all context is dropped there, including the record that the EEPROM load has finished. No PME can come from D3cold.

Top module: `pm_state_ctrl`

## Requirements
- R1: After reset the block is in D0 uninitialized. `pm_state` uses the codes 00 = D0 uninitialized, 01 = D0 active, 10 = D3hot, 11 = D3cold. After reset `pwr_field` is 00, `pme_req` is 0 and `cfg_resp_en` is 1.
- R2: Until `eeprom_done` has been seen on an earlier clock edge, the block stays in D0 uninitialized. Command writes, `mem_access_en` and power-state writes all leave it there.
- R3: Once the load is recorded, D0 uninitialized becomes D0 active one cycle after either of two events. One is a write to byte offset 0x004 with any of data bits [2:0] set. The other is a `mem_access_en` pulse. A Command write with bits [2:0] all zero has no effect.
- R4: A write of 11 to data bits [1:0] at byte offset 0x044, in either D0 substate after the load, enters D3hot on the next cycle. This takes priority over a same-cycle `mem_access_en`. `pwr_field` reads 11 in D3hot and 00 in every other state.
- R5: In D3hot, a write of 00 to the power-state field returns the block to D0 uninitialized only when `up_link_l0s` and `dn_link_l0s` are both high. The EEPROM-loaded record is kept. Otherwise the block stays in D3hot.
- R6: Power-state writes of 01 or 10 are ignored. The state and `pwr_field` do not change.
- R7: `cfg_resp_en` is high in every state except D3cold, and that includes D3hot.
- R8: A rising edge of `hotplug_evt` while the block is in D3hot and stays there gives `pme_req` high for exactly one cycle on the next cycle. A level held high gives only one pulse. Hot-plug edges in other states give no pulse.
- R9: When `main_pwr_ok` is low, the block is in D3cold on the next cycle, whatever its state. A hot-plug edge in that same cycle gives no PME.
- R10: When `main_pwr_ok` returns in D3cold, the block goes to D0 uninitialized with the load record cleared. It needs a new `eeprom_done` before it can be activated.
- R11: A hot-plug edge in the same cycle as a successful D0 write in D3hot gives no PME, because the block does not stay in D3hot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_addr | input | CFG_AW (12) | Configuration byte offset |
| cfg_wr_data | input | CFG_DW (8) | Low byte of the write data |
| mem_access_en | input | 1 | Memory access enable event |
| eeprom_done | input | 1 | Serial EEPROM load complete |
| up_link_l0s | input | 1 | Upstream link is in L0s |
| dn_link_l0s | input | 1 | Downstream link is in L0s |
| hotplug_evt | input | 1 | Hot-plug event level |
| main_pwr_ok | input | 1 | Main power present |
| pm_state | output | 2 | Current power state code |
| pwr_field | output | 2 | Power-state field readback |
| pme_req | output | 1 | One-cycle PME request |
| cfg_resp_en | output | 1 | Configuration responses allowed |

## Verification
A PME request and a state exit from D3hot can fall in the same cycle. The bench provokes this in two ways. In one, a hot-plug edge arrives together with a valid D0 write while both links are in L0s. In the other, a hot-plug edge arrives while main power drops. In both cases it requires no PME pulse, and the new state (D0 uninitialized or D3cold) must appear on the following cycle. A second clash, a D3 write together with a memory-access-enable event in D0 uninitialized, is judged by which state appears.

// File: rtl/pm_pkg.sv
package pm_pkg;

    typedef enum logic [1:0] {
        PM_D0_UNINIT = 2'b00,
        PM_D0_ACTIVE = 2'b01,
        PM_D3_HOT    = 2'b10,
        PM_D3_COLD   = 2'b11
    } pm_state_e;

    // Decoded view of one configuration write
    typedef struct packed {
        logic cmd_enable;   // Command write with an enable bit set
        logic pm_to_d3;     // power-state field written with 11
        logic pm_to_d0;     // power-state field written with 00
    } cfg_req_t;

    typedef struct packed {
        pm_state_e state;
        logic      loaded;
    } fsm_reg_t;

    typedef struct packed {
        logic hp_prev;
        logic pme;
    } pme_reg_t;

    localparam logic [1:0] FIELD_D0 = 2'b00;
    localparam logic [1:0] FIELD_D3 = 2'b11;

    function automatic logic [1:0] field_of(input pm_state_e s);
        return (s == PM_D3_HOT) ? FIELD_D3 : FIELD_D0;
    endfunction

endpackage

// File: rtl/pm_cfg_decode.sv
module pm_cfg_decode
    import pm_pkg::*;
#(
    parameter int unsigned CFG_AW = 12,
    parameter int unsigned CFG_DW = 8,
    parameter logic [CFG_AW-1:0] CMD_OFS = 12'h004,
    parameter logic [CFG_AW-1:0] PMC_OFS = 12'h044
) (
    input  logic              wr_en,
    input  logic [CFG_AW-1:0] wr_addr,
    input  logic [CFG_DW-1:0] wr_data,
    output cfg_req_t          req
);
    localparam int unsigned ENB_W = 3;

    logic cmd_hit;
    logic pmc_hit;
    logic unused_data_bits;

    assign cmd_hit = wr_en && (wr_addr == CMD_OFS);
    assign pmc_hit = wr_en && (wr_addr == PMC_OFS);
    assign unused_data_bits = ^wr_data[CFG_DW-1:ENB_W];

    always_comb begin
        req            = '0;
        req.cmd_enable = cmd_hit && (|wr_data[ENB_W-1:0]);
        req.pm_to_d3   = pmc_hit && (wr_data[1:0] == FIELD_D3);
        req.pm_to_d0   = pmc_hit && (wr_data[1:0] == FIELD_D0);
    end

endmodule

// File: rtl/pm_fsm.sv
module pm_fsm
    import pm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  cfg_req_t  req,
    input  logic      mem_access_en,
    input  logic      eeprom_done,
    input  logic      links_l0s,
    input  logic      main_pwr_ok,
    output pm_state_e state_q,
    output pm_state_e state_d
);
    fsm_reg_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (eeprom_done) r_d.loaded = 1'b1;
        unique case (r_q.state)
            PM_D0_UNINIT: begin
                if (r_q.loaded) begin
                    if (req.pm_to_d3)
                        r_d.state = PM_D3_HOT;
                    else if (req.cmd_enable || mem_access_en)
                        r_d.state = PM_D0_ACTIVE;
                end
            end
            PM_D0_ACTIVE: begin
                if (req.pm_to_d3) r_d.state = PM_D3_HOT;
            end
            PM_D3_HOT: begin
                if (req.pm_to_d0 && links_l0s) r_d.state = PM_D0_UNINIT;
            end
            PM_D3_COLD: begin
                if (main_pwr_ok) begin
                    r_d.state  = PM_D0_UNINIT;
                    r_d.loaded = 1'b0;
                end
            end
            default: r_d.state = PM_D0_UNINIT;
        endcase
        if (!main_pwr_ok) begin
            r_d.state  = PM_D3_COLD;
            r_d.loaded = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state  <= PM_D0_UNINIT;
            r_q.loaded <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign state_q = r_q.state;
    assign state_d = r_d.state;

endmodule

// File: rtl/pm_wake_pulse.sv
module pm_wake_pulse
    import pm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      hotplug_evt,
    input  pm_state_e cur_state,
    input  pm_state_e nxt_state,
    output logic      pme_req
);
    pme_reg_t p_q, p_d;

    always_comb begin
        p_d         = p_q;
        p_d.hp_prev = hotplug_evt;
        // raise only when the port is in D3hot now and remains there
        p_d.pme     = hotplug_evt && !p_q.hp_prev
                      && (cur_state == PM_D3_HOT)
                      && (nxt_state == PM_D3_HOT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    assign pme_req = p_q.pme;

endmodule

// File: rtl/pm_state_ctrl.sv
module pm_state_ctrl
    import pm_pkg::*;
#(
    parameter int unsigned CFG_AW = 12,
    parameter int unsigned CFG_DW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [CFG_AW-1:0] cfg_wr_addr,
    input  logic [CFG_DW-1:0] cfg_wr_data,
    input  logic              mem_access_en,
    input  logic              eeprom_done,
    input  logic              up_link_l0s,
    input  logic              dn_link_l0s,
    input  logic              hotplug_evt,
    input  logic              main_pwr_ok,
    output logic [1:0]        pm_state,
    output logic [1:0]        pwr_field,
    output logic              pme_req,
    output logic              cfg_resp_en
);
    cfg_req_t  req;
    pm_state_e st_q;
    pm_state_e st_d;

    pm_cfg_decode #(
        .CFG_AW (CFG_AW),
        .CFG_DW (CFG_DW)
    ) u_dec (
        .wr_en   (cfg_wr_en),
        .wr_addr (cfg_wr_addr),
        .wr_data (cfg_wr_data),
        .req     (req)
    );

    pm_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .req           (req),
        .mem_access_en (mem_access_en),
        .eeprom_done   (eeprom_done),
        .links_l0s     (up_link_l0s && dn_link_l0s),
        .main_pwr_ok   (main_pwr_ok),
        .state_q       (st_q),
        .state_d       (st_d)
    );

    pm_wake_pulse u_pme (
        .clk         (clk),
        .rst_n       (rst_n),
        .hotplug_evt (hotplug_evt),
        .cur_state   (st_q),
        .nxt_state   (st_d),
        .pme_req     (pme_req)
    );

    assign pm_state    = st_q;
    assign pwr_field   = field_of(st_q);
    assign cfg_resp_en = (st_q != PM_D3_COLD);

endmodule

// File: rtl/pm_state_ctrl_chk.sv
module pm_state_ctrl_chk #(
    parameter int unsigned CFG_AW = 12,
    parameter int unsigned CFG_DW = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr_en,
    input logic [CFG_AW-1:0] cfg_wr_addr,
    input logic [CFG_DW-1:0] cfg_wr_data,
    input logic              mem_access_en,
    input logic              up_link_l0s,
    input logic              dn_link_l0s,
    input logic              main_pwr_ok,
    input logic [1:0]        pm_state,
    input logic [1:0]        pwr_field,
    input logic              pme_req
);
    logic pmc_wr;
    assign pmc_wr = cfg_wr_en && (cfg_wr_addr == 12'h044);

    // R9: power loss lands in D3cold
    p_cold_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !main_pwr_ok |=> pm_state == 2'b11);

    // R8: a PME request only ever appears in D3hot
    p_pme_only_hot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pme_req |-> pm_state == 2'b10);

    // R8: the request is a single-cycle pulse
    p_pme_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pme_req |=> !pme_req);

    // R6: unsupported encodings leave state and readback alone
    p_unsup_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pmc_wr && (cfg_wr_data[1:0] == 2'b01 || cfg_wr_data[1:0] == 2'b10)
        && main_pwr_ok && !mem_access_en && pm_state != 2'b11
        |=> $stable(pm_state) && $stable(pwr_field));

    // R5: D3hot is kept unless both links report L0s
    p_hot_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pm_state == 2'b10 && main_pwr_ok && !(up_link_l0s && dn_link_l0s)
        |=> pm_state == 2'b10);

    // R10: D3cold only exits to D0 uninitialized
    p_cold_exit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pm_state == 2'b11 |=> pm_state == 2'b11 || pm_state == 2'b00);

endmodule

bind pm_state_ctrl pm_state_ctrl_chk #(
    .CFG_AW (CFG_AW),
    .CFG_DW (CFG_DW)
) u_chk (.*);

// File: tb/pm_state_ctrl_bench.sv
module pm_state_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [11:0] cfg_wr_addr = '0;
    logic [7:0]  cfg_wr_data = '0;
    logic        mem_access_en = 1'b0;
    logic        eeprom_done = 1'b0;
    logic        up_link_l0s = 1'b0;
    logic        dn_link_l0s = 1'b0;
    logic        hotplug_evt = 1'b0;
    logic        main_pwr_ok = 1'b1;
    logic [1:0]  pm_state;
    logic [1:0]  pwr_field;
    logic        pme_req;
    logic        cfg_resp_en;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    pm_state_ctrl u_pm_state_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_wr_en     (cfg_wr_en),
        .cfg_wr_addr   (cfg_wr_addr),
        .cfg_wr_data   (cfg_wr_data),
        .mem_access_en (mem_access_en),
        .eeprom_done   (eeprom_done),
        .up_link_l0s   (up_link_l0s),
        .dn_link_l0s   (dn_link_l0s),
        .hotplug_evt   (hotplug_evt),
        .main_pwr_ok   (main_pwr_ok),
        .pm_state      (pm_state),
        .pwr_field     (pwr_field),
        .pme_req       (pme_req),
        .cfg_resp_en   (cfg_resp_en)
    );

    // Row: kind(2: 0 none,1 cmd,2 pm) data(3) mem eep up dn hp pwr exp_state(2) exp_pme
    localparam int NV = 26;
    localparam logic [13:0] VEC [NV] = '{
        14'b00_000_0_0_0_0_0_1_00_0,  // 0 idle
        14'b01_111_0_0_0_0_0_1_00_0,  // 1 cmd before load
        14'b00_000_1_0_0_0_0_1_00_0,  // 2 mem before load
        14'b10_011_0_0_0_0_0_1_00_0,  // 3 D3 write before load
        14'b00_000_0_1_0_0_0_1_00_0,  // 4 load done
        14'b01_000_0_0_0_0_0_1_00_0,  // 5 cmd no enable bits
        14'b01_010_0_0_0_0_0_1_01_0,  // 6 cmd memory enable
        14'b10_001_0_0_0_0_0_1_01_0,  // 7 pm 01
        14'b10_010_0_0_0_0_0_1_01_0,  // 8 pm 10
        14'b00_000_0_0_0_0_1_1_01_0,  // 9 hot-plug in D0
        14'b10_011_0_0_0_0_0_1_10_0,  // 10 enter D3hot
        14'b10_001_0_0_0_0_0_1_10_0,  // 11 pm 01 in D3hot
        14'b00_000_0_0_0_0_1_1_10_1,  // 12 hot-plug edge
        14'b00_000_0_0_0_0_1_1_10_0,  // 13 held
        14'b00_000_0_0_0_0_0_1_10_0,  // 14 released
        14'b10_000_0_0_1_0_0_1_10_0,  // 15 D0 write, up only
        14'b10_000_0_0_0_1_0_1_10_0,  // 16 D0 write, down only
        14'b10_000_0_0_1_1_0_1_00_0,  // 17 D0 write, both
        14'b00_000_1_0_0_0_0_1_01_0,  // 18 mem access, load kept
        14'b10_011_0_0_0_0_0_1_10_0,  // 19 back to D3hot
        14'b00_000_0_0_0_0_0_0_11_0,  // 20 power lost
        14'b00_000_0_0_0_0_1_0_11_0,  // 21 hot-plug in D3cold
        14'b00_000_0_0_0_0_0_1_00_0,  // 22 power back
        14'b01_001_0_0_0_0_0_1_00_0,  // 23 cmd, load lost
        14'b00_000_0_1_0_0_0_1_00_0,  // 24 reload
        14'b01_100_0_0_0_0_0_1_01_0   // 25 cmd bus master
    };

    string tags [NV] = '{"R1","R2","R2","R2","R2","R3","R3","R6","R6","R8",
                         "R4","R6","R8","R8","R8","R5","R5","R5","R3","R4",
                         "R9","R9","R10","R10","R10","R10"};

    task automatic check(input bit ok, input string tag, input string what,
                         input int got, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    task automatic check_outs(input logic [1:0] es, input logic ep, input string tag);
        check(pm_state == es, tag, "pm_state", pm_state, es);
        check(pme_req == ep, (ep ? tag : "R8"), "pme_req", pme_req, ep);
        check(pwr_field == ((es == 2'b10) ? 2'b11 : 2'b00), "R4", "pwr_field",
              pwr_field, (es == 2'b10) ? 3 : 0);
        check(cfg_resp_en == (es != 2'b11), "R7", "cfg_resp_en",
              cfg_resp_en, (es != 2'b11) ? 1 : 0);
    endtask

    task automatic step(input logic [1:0] kind, input logic [2:0] d, input logic mem,
                        input logic eep, input logic up, input logic dn, input logic hp,
                        input logic pwr, input logic [1:0] es, input logic ep,
                        input string tag);
        cfg_wr_en     = (kind != 2'd0);
        cfg_wr_addr   = (kind == 2'd2) ? 12'h044 : 12'h004;
        cfg_wr_data   = {5'b0, d};
        mem_access_en = mem;
        eeprom_done   = eep;
        up_link_l0s   = up;
        dn_link_l0s   = dn;
        hotplug_evt   = hp;
        main_pwr_ok   = pwr;
        @(posedge clk);
        @(negedge clk);
        check_outs(es, ep, tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_outs(2'b00, 1'b0, "R1");
        rst_n = 1'b1;
        @(negedge clk);
        check_outs(2'b00, 1'b0, "R1");

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][13:12], VEC[i][11:9], VEC[i][8], VEC[i][7], VEC[i][6],
                 VEC[i][5], VEC[i][4], VEC[i][3], VEC[i][2:1], VEC[i][0], tags[i]);
        end

        // Now in D0 active with the load recorded
        step(2'd2, 3'b011, 0, 0, 0, 0, 0, 1, 2'b10, 0, "R4");
        step(2'd2, 3'b000, 0, 0, 1, 1, 0, 1, 2'b00, 0, "R5");
        // R4: D3 write wins over a same-cycle memory access enable
        step(2'd2, 3'b011, 1, 0, 0, 0, 0, 1, 2'b10, 0, "R4");
        // R11: hot-plug edge together with a successful D0 write
        step(2'd2, 3'b000, 0, 0, 1, 1, 1, 1, 2'b00, 0, "R11");
        step(2'd0, 3'b000, 0, 0, 0, 0, 0, 1, 2'b00, 0, "R11");
        step(2'd2, 3'b011, 0, 0, 0, 0, 0, 1, 2'b10, 0, "R4");
        // R9: hot-plug edge together with power loss
        step(2'd0, 3'b000, 0, 0, 0, 0, 1, 0, 2'b11, 0, "R9");
        step(2'd0, 3'b000, 0, 0, 0, 0, 0, 0, 2'b11, 0, "R9");
        step(2'd0, 3'b000, 0, 0, 0, 0, 0, 1, 2'b00, 0, "R10");
        step(2'd0, 3'b000, 0, 1, 0, 0, 0, 1, 2'b00, 0, "R2");
        step(2'd1, 3'b111, 0, 0, 0, 0, 0, 1, 2'b01, 0, "R3");
        // R1: reset from D0 active
        rst_n = 1'b0;
        @(negedge clk);
        check_outs(2'b00, 1'b0, "R1");
        rst_n = 1'b1;
        step(2'd1, 3'b001, 0, 0, 0, 0, 0, 1, 2'b00, 0, "R2");

        finish_run();
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

endmodule